// File: doc/BRIEF.md
# Systolic Instruction Ripple Chain

This block is the instruction path of a shader array in which the processing elements do not receive a broadcast. A single fetch port feeds element 0. On every cycle, each element executes the instruction it holds and passes it to its right-hand neighbour. Every thread of a warp therefore runs the same instruction stream, and each element runs it one cycle later than the element on its left. Accesses that neighbouring threads make to a shared unit are spread out in time as a result. The chain fills in as many cycles as there are elements, and a new warp can follow the previous one into element 0 with no gap.

Executing an instruction is abstracted as follows:
- Each element has a stall input, and a stalled element keeps its instruction.
- Each element has a retire output, which shows the cycle in which that element finished the instruction.
- A stalled element sends a bubble to the element on its right.
- A stalled element holds back the elements on its left, and through them the fetch port. Nothing is skipped, duplicated or reordered.

Each instruction carries a warp tag and an end-of-thread flag. The chain reports when the end-of-thread instruction leaves the first element and when it leaves the last element.

Top module: `ripple_issue_chain`

## Requirements
- R1: While reset is asserted and after its release, every element is empty, `fetch_ready` is high, and `head_done` and `tail_done` are low.
- R2: When `fetch_valid` and `fetch_ready` are both high in a cycle, the offered instruction is held in element 0 in the next cycle. `fetch_ready` is high whenever element 0 is empty.
- R3: When no element stalls, an instruction accepted at the fetch port in cycle n is retired by element k in cycle n+1+k. Filling the chain therefore takes one cycle per element.
- R4: Every element retires exactly the sequence of instructions accepted at the fetch port, in acceptance order, with none dropped or repeated. This holds under any pattern of stalls.
- R5: An element that is valid and has its stall input high keeps its instruction unchanged into the next cycle and does not retire in that cycle. An element retires only when it is valid and its stall input is low.
- R6: When an element is stalled and the element on its right is free to move, the element on its right is empty in the next cycle. It receives a bubble, not a copy of the stalled instruction.
- R7: An element that cannot hand off its instruction holds the elements to its left. `fetch_ready` is low in any cycle in which element 0 is valid and stalled.
- R8: After the end-of-thread instruction of a warp is accepted, the first instruction of the next warp is accepted in the following cycle when it is offered and nothing stalls. The chain does not wait for the last element to finish.
- R9: `head_done` is high for exactly the cycle after element 0 retires an instruction whose end-of-thread flag is set. `head_tag` gives that instruction's warp tag in that cycle.
- R10: `tail_done` is high for exactly the cycle after the last element retires an instruction whose end-of-thread flag is set. `tail_tag` gives that instruction's warp tag in that cycle.
- R11: A stall input on an empty element has no effect. With every element empty and every stall input high, `fetch_ready` stays high and an offered instruction is accepted into element 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | An instruction is offered at the fetch port |
| fetch_ready | output | 1 | Element 0 can take an instruction in this cycle |
| fetch_op | input | OP_W (16) | Instruction word |
| fetch_tag | input | TAG_W (4) | Warp tag of the offered instruction |
| fetch_eot | input | 1 | Offered instruction is the last one of its thread |
| pe_stall | input | NUM_PE (16) | Per-element execution stall, bit i for element i |
| pe_valid | output | NUM_PE (16) | Element i holds an instruction |
| pe_op | output | NUM_PE*OP_W (256) | Instruction held by each element; element i uses bits [i*16 +: 16] |
| pe_retire | output | NUM_PE (16) | Element i finishes its instruction in this cycle |
| head_done | output | 1 | Element 0 retired an end-of-thread instruction in the previous cycle |
| head_tag | output | TAG_W (4) | Warp tag for `head_done` |
| tail_done | output | 1 | The last element retired an end-of-thread instruction in the previous cycle |
| tail_tag | output | TAG_W (4) | Warp tag for `tail_done` |

## Verification
The hardest case to reach is a stall that begins in the middle of the chain while the elements on both sides are full. In that case the element on the right must drain to a bubble and the elements on the left must freeze, and the stall must propagate back to the fetch port without losing an instruction. The stimulus keeps `fetch_valid` high so that the chain is full. It then holds a single stall for several cycles at element 0, at a middle element and at the last element. After that it runs a long stretch of random overlapping stalls with random fetch gaps, which creates chains of held elements of every length. Per-element reference queues catch any reordering, and a cycle-exact latency model catches any timing slip in the stall-free phases.

// File: rtl/ric_pkg.sv
package ric_pkg;
  localparam int OP_W  = 16;
  localparam int TAG_W = 4;

  typedef struct packed {
    logic             eot;
    logic [TAG_W-1:0] tag;
    logic [OP_W-1:0]  op;
  } slot_t;
endpackage

// File: rtl/ric_hold_chain.sv
module ric_hold_chain #(
  parameter int N = 16
) (
  input  logic [N-1:0] valid,
  input  logic [N-1:0] stall,
  output logic [N-1:0] hold
);
  // An element holds when it is occupied and either stalls itself or cannot
  // hand its instruction to a right neighbour that is itself holding.
  always_comb begin
    hold        = '0;
    hold[N-1]   = valid[N-1] & stall[N-1];
    for (int i = N - 2; i >= 0; i--) begin
      hold[i] = valid[i] & (stall[i] | hold[i+1]);
    end
  end
endmodule

// File: rtl/ric_slot.sv
module ric_slot
  import ric_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  slot_t in_slot,
  input  logic  hold,
  output logic  q_valid,
  output slot_t q_slot
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_slot  <= '0;
    end else if (!hold) begin
      q_valid <= in_valid;
      q_slot  <= in_slot;
    end
  end

  // R5: a held element keeps its instruction
  p_hold_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    hold |=> (q_valid && $stable(q_slot)));

  // R3: a free element takes what its left neighbour hands over
  p_shift_in_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold && in_valid) |=> (q_valid && q_slot == $past(in_slot)));

  // R6: nothing handed over means a bubble
  p_bubble_in_r6: assert property (@(posedge clk) disable iff (rst)
    (!hold && !in_valid) |=> !q_valid);
endmodule

// File: rtl/ric_done.sv
module ric_done
  import ric_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [TAG_W-1:0] tag_in,
  output logic             done,
  output logic [TAG_W-1:0] tag_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      tag_out <= '0;
    end else begin
      done <= fire;
      if (fire) tag_out <= tag_in;
    end
  end

  // R9 (head instance) and R10 (tail instance): single-cycle report with tag
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> (done && tag_out == $past(tag_in)));

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !done);
endmodule

// File: rtl/ripple_issue_chain.sv
module ripple_issue_chain
  import ric_pkg::*;
#(
  parameter int NUM_PE = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fetch_valid,
  output logic                   fetch_ready,
  input  logic [OP_W-1:0]        fetch_op,
  input  logic [TAG_W-1:0]       fetch_tag,
  input  logic                   fetch_eot,
  input  logic [NUM_PE-1:0]      pe_stall,
  output logic [NUM_PE-1:0]      pe_valid,
  output logic [NUM_PE*OP_W-1:0] pe_op,
  output logic [NUM_PE-1:0]      pe_retire,
  output logic                   head_done,
  output logic [TAG_W-1:0]       head_tag,
  output logic                   tail_done,
  output logic [TAG_W-1:0]       tail_tag
);
  localparam int LAST = NUM_PE - 1;

  slot_t             slot_q  [NUM_PE];
  slot_t             slot_in [NUM_PE];
  logic [NUM_PE-1:0] v_q;
  logic [NUM_PE-1:0] take;
  logic [NUM_PE-1:0] hold;

  ric_hold_chain #(.N(NUM_PE)) u_hold (
    .valid (v_q),
    .stall (pe_stall),
    .hold  (hold)
  );

  assign pe_retire   = v_q & ~hold;
  assign fetch_ready = ~hold[0];
  assign pe_valid    = v_q;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    if (g == 0) begin : g_head
      assign take[g]    = fetch_valid & fetch_ready;
      assign slot_in[g] = '{eot: fetch_eot, tag: fetch_tag, op: fetch_op};
    end else begin : g_body
      assign take[g]    = pe_retire[g-1];
      assign slot_in[g] = slot_q[g-1];
    end

    ric_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .in_valid (take[g]),
      .in_slot  (slot_in[g]),
      .hold     (hold[g]),
      .q_valid  (v_q[g]),
      .q_slot   (slot_q[g])
    );

    assign pe_op[g*OP_W +: OP_W] = slot_q[g].op;

    if (g < LAST) begin : g_bubble_chk
      // R6: a stalled element feeds a bubble to a free right neighbour
      p_stall_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        (v_q[g] && pe_stall[g] && !hold[g+1]) |=> !v_q[g+1]);
    end
  end

  ric_done u_head_done (
    .clk     (clk),
    .rst     (rst),
    .fire    (pe_retire[0] & slot_q[0].eot),
    .tag_in  (slot_q[0].tag),
    .done    (head_done),
    .tag_out (head_tag)
  );

  ric_done u_tail_done (
    .clk     (clk),
    .rst     (rst),
    .fire    (pe_retire[LAST] & slot_q[LAST].eot),
    .tag_in  (slot_q[LAST].tag),
    .done    (tail_done),
    .tag_out (tail_tag)
  );

  // R7: a stalled, occupied element 0 blocks the fetch port
  p_fetch_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (pe_valid[0] && pe_stall[0]) |-> !fetch_ready);

  // R10: the warp leaves the last element and is reported
  p_tail_report_r10: assert property (@(posedge clk) disable iff (rst)
    (pe_retire[LAST] && slot_q[LAST].eot) |=> tail_done);

  // R2: an empty element 0 always accepts
  p_ready_empty_r2: assert property (@(posedge clk) disable iff (rst)
    !pe_valid[0] |-> fetch_ready);
endmodule

// File: tb/ripple_issue_chain_tb.sv
module ripple_issue_chain_tb;
  import ric_pkg::*;

  localparam int N     = 16;
  localparam int LIMIT = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fetch_valid = 1'b0;
  logic              fetch_ready;
  logic [OP_W-1:0]   fetch_op = '0;
  logic [TAG_W-1:0]  fetch_tag = '0;
  logic              fetch_eot = 1'b0;
  logic [N-1:0]      pe_stall = '0;
  logic [N-1:0]      pe_valid;
  logic [N*OP_W-1:0] pe_op;
  logic [N-1:0]      pe_retire;
  logic              head_done, tail_done;
  logic [TAG_W-1:0]  head_tag, tail_tag;

  always #10 clk = ~clk;

  ripple_issue_chain #(.NUM_PE(N)) u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_op(fetch_op), .fetch_tag(fetch_tag), .fetch_eot(fetch_eot),
    .pe_stall(pe_stall), .pe_valid(pe_valid), .pe_op(pe_op), .pe_retire(pe_retire),
    .head_done(head_done), .head_tag(head_tag), .tail_done(tail_done), .tail_tag(tail_tag)
  );

  typedef struct {
    int op;
    int tag;
    bit eot;
    int cyc;
  } ent_t;

  ent_t q [N][$];
  int checks = 0, fails = 0, cyc = 0;
  bit clean = 0, single = 0, accepted = 0, finished = 0;
  bit exp_head = 0, exp_tail = 0;
  int exp_head_tag = 0, exp_tail_tag = 0;
  bit prev_st [N];
  int prev_opv [N];
  bit prev_fire = 0;
  int prev_fire_op = 0;
  int last_eot_fire = -10;
  int nxt_op = 1, nxt_idx = 0, warp_len = 6, warp_id = 1;

  function automatic int opat(int i);
    return int'(pe_op[i*OP_W +: OP_W]);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model: per-element expected streams plus timing expectations
  always @(negedge clk) begin
    if (rst) begin
      accepted = 0;
      for (int i = 0; i < N; i++) prev_st[i] = 0;
    end else begin
      bit n_head, n_tail;
      int n_head_tag, n_tail_tag;
      cyc++;
      n_head = 0; n_tail = 0; n_head_tag = 0; n_tail_tag = 0;

      chk(head_done == exp_head, "R9 head_done", int'(head_done), int'(exp_head));
      if (exp_head) chk(int'(head_tag) == exp_head_tag, "R9 head_tag", int'(head_tag), exp_head_tag);
      chk(tail_done == exp_tail, "R10 tail_done", int'(tail_done), int'(exp_tail));
      if (exp_tail) chk(int'(tail_tag) == exp_tail_tag, "R10 tail_tag", int'(tail_tag), exp_tail_tag);

      if (prev_fire)
        chk(pe_valid[0] && opat(0) == prev_fire_op, "R2 landed in element 0", opat(0), prev_fire_op);

      for (int i = 0; i < N; i++) begin
        if (prev_st[i])
          chk(pe_valid[i] && opat(i) == prev_opv[i], "R5 held instruction", opat(i), prev_opv[i]);
      end

      if (single) begin
        for (int i = 0; i < N - 1; i++) begin
          if (prev_st[i]) chk(!pe_valid[i+1], "R6 bubble", int'(pe_valid[i+1]), 0);
        end
      end

      if (!pe_valid[0]) begin
        if (pe_stall != '0) chk(fetch_ready, "R11 empty stall ignored", int'(fetch_ready), 1);
        else                chk(fetch_ready, "R2 ready when empty", int'(fetch_ready), 1);
      end
      if (pe_valid[0] && pe_stall[0]) chk(!fetch_ready, "R7 ready low", int'(fetch_ready), 0);
      if (last_eot_fire == cyc - 1 && fetch_valid && pe_stall == '0)
        chk(fetch_ready, "R8 next warp accepted", int'(fetch_ready), 1);

      for (int i = 0; i < N; i++) begin
        if (pe_retire[i]) begin
          chk(pe_valid[i] && !pe_stall[i], "R5 retire only when free", int'(pe_stall[i]), 0);
          if (q[i].size() == 0) begin
            chk(0, "R4 unexpected retire", opat(i), -1);
          end else begin
            ent_t e;
            e = q[i].pop_front();
            chk(opat(i) == e.op, "R4 order", opat(i), e.op);
            if (clean) chk(cyc - e.cyc == i + 1, "R3 latency", cyc - e.cyc, i + 1);
            if (i == 0 && e.eot)     begin n_head = 1; n_head_tag = e.tag; end
            if (i == N - 1 && e.eot) begin n_tail = 1; n_tail_tag = e.tag; end
          end
        end else if (clean && pe_valid[i] && pe_stall == '0) begin
          chk(0, "R3 missing retire", 0, 1);
        end
      end

      accepted = fetch_valid && fetch_ready;
      prev_fire = accepted;
      prev_fire_op = int'(fetch_op);
      if (accepted) begin
        ent_t e;
        e.op = int'(fetch_op); e.tag = int'(fetch_tag); e.eot = fetch_eot; e.cyc = cyc;
        for (int i = 0; i < N; i++) q[i].push_back(e);
        if (fetch_eot) last_eot_fire = cyc;
      end

      exp_head = n_head; exp_head_tag = n_head_tag;
      exp_tail = n_tail; exp_tail_tag = n_tail_tag;
      for (int i = 0; i < N; i++) begin
        prev_st[i]  = pe_valid[i] && pe_stall[i];
        prev_opv[i] = opat(i);
      end
    end
  end

  task automatic present();
    fetch_op  = OP_W'(nxt_op);
    fetch_tag = TAG_W'(warp_id);
    fetch_eot = (nxt_idx == warp_len - 1);
  endtask

  task automatic cycle(bit fv, logic [N-1:0] st);
    @(posedge clk);
    #2;
    if (accepted) begin
      nxt_op++;
      nxt_idx++;
      if (nxt_idx >= warp_len) begin
        nxt_idx = 0;
        warp_id++;
      end
    end
    fetch_valid = fv;
    present();
    pe_stall = st;
  endtask

  task automatic drain(int n);
    for (int k = 0; k < n; k++) cycle(1'b0, '0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: state during reset
    chk(pe_valid == '0, "R1 empty in reset", int'(pe_valid), 0);
    chk(fetch_ready, "R1 ready in reset", int'(fetch_ready), 1);
    chk(!head_done && !tail_done, "R1 done low", int'(head_done | tail_done), 0);
    @(posedge clk);
    #2;
    rst = 1'b0;
    #5;
    chk(pe_valid == '0, "R1 empty after reset", int'(pe_valid), 0);

    // Back-to-back warps with no stalls: R3, R8, R9, R10
    clean = 1;
    warp_len = 6;
    for (int k = 0; k < 30; k++) cycle(1'b1, '0);
    drain(20);
    // Gapped fetch, still stall-free
    warp_len = 4;
    for (int k = 0; k < 30; k++) cycle(k % 3 != 0, '0);
    drain(20);
    clean = 0;

    // Single stalls at head, middle and tail on a full chain: R5, R6, R7
    single = 1;
    warp_len = 8;
    foreach (prev_st[e]) begin
      if (e == 0 || e == 7 || e == N - 1) begin
        for (int k = 0; k < 24; k++) begin
          logic [N-1:0] st;
          st = '0;
          if (k >= 18 && k < 21) st[e] = 1'b1;
          cycle(1'b1, st);
        end
        drain(20);
      end
    end
    single = 0;

    // Random overlapping stalls and fetch gaps: R4
    warp_len = 5;
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] st;
      for (int i = 0; i < N; i++) st[i] = ($urandom % 12 == 0);
      cycle($urandom % 4 != 0, st);
    end
    drain(60);

    // R11: stalls on an empty chain, then release
    for (int k = 0; k < 3; k++) cycle(1'b1, '1);
    drain(25);

    #5;
    for (int i = 0; i < N; i++)
      chk(q[i].size() == 0, "R4 every instruction retired", q[i].size(), 0);
    chk(pe_valid == '0, "R4 chain drained", int'(pe_valid), 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
      summary();
      $finish;
    end
  end
endmodule